// File: doc/BRIEF.md
# Write-Protection Command Detector

This block sits between a host write path and the page-write engine of a paged non-volatile memory. It sees every write transaction, each an address and a data word made of several identical byte lanes. It decides in the same cycle whether that write may be loaded into the page buffer. The block holds a persistent protection mode. Only exact address/data command sequences can change that mode. While protection is on, a burst of data loads is accepted only when it directly follows the three-write unlock sequence. After that sequence, the mode stays protected.

The three-write sequence and the six-write sequence are both tracked by one step counter. A change of mode starts a lockout of `LOCK_CYCLES` clock cycles. The lockout stands in for the memory's internal program time, and during it every write is refused and ignored. A permission window opened by the unlock sequence stays open until the page-write engine reports that its program cycle is done.

Top module: `wp_cmd_guard`

## Requirements
- R1: After reset the mode is unprotected (`prot_mode`=0), `seq_state` is 0 and `wr_permit` is 0 while `wr_valid` is low.
- R2: In unprotected mode, outside lockout, a write that does not advance a command sequence raises `wr_permit` in the same cycle as `wr_valid`.
- R3: A command write carries the same byte in all lanes. The protect sequence is address 0x5555 with byte 0xAA, then the 0x55 step, then address 0x5555 with byte 0xA0. Completing it from unprotected mode sets `prot_mode`. A write consumed as a sequence step never raises `wr_permit`.
- R4: A mode change starts a lockout that lasts `LOCK_CYCLES` cycles. During the lockout `seq_state` is 7, no write is permitted and no write affects the mode or the step count. When the lockout ends, `seq_state` returns to 0.
- R5: In protected mode, with no window open, a write that is not a sequence step is refused and leaves `prot_mode` at 1.
- R6: In protected mode, completing the protect sequence opens a data window (`seq_state`=6) without a lockout. Every write in the window is permitted, and `prot_mode` stays 1.
- R7: A `prog_done` pulse closes the data window. After it, unsequenced writes in protected mode are refused again.
- R8: The unprotect sequence is 0x5555/0xAA, the 0x55 step, 0x5555/0x80, 0x5555/0xAA, the 0x55 step, 0x5555/0x20. Completing it clears `prot_mode` and starts the lockout.
- R9: A write that does not match the next expected step returns `seq_state` to 0. That write is permitted if and only if the mode is unprotected.
- R10: A write whose byte lanes are not all equal is never taken as a sequence step.
- R11: The 0x55 step is accepted at address 0x2AAA and also at address 0xAAAA.
- R12: `seq_state` counts the sequence steps matched so far, from 1 to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write transaction present this cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8*LANES | Write data, one byte per lane |
| prog_done | input | 1 | Pulse from the page-write engine when its program cycle finishes |
| wr_permit | output | 1 | The current write may be loaded into the page buffer |
| prot_mode | output | 1 | 1 when protection is on |
| seq_state | output | 3 | 0 idle, 1 to 5 steps matched, 6 data window open, 7 lockout |

## Verification
The embedded assertions check five properties on every cycle. No write is permitted during lockout. A permit always comes with a valid write. The mode changes only after a write. A change of mode enters lockout. In protected mode, outside the data window, nothing is permitted.

The directed scenarios are the only way to show the exact command encodings. They also show the alternate 0x55 address, the abort on a broken or lane-mismatched sequence, the window closing on `prog_done`, and the length of the lockout.

// File: rtl/wp_cmd_guard.sv
module wp_cmd_guard #(
  parameter int ADDR_W      = 17,
  parameter int LANES       = 5,
  parameter int LOCK_CYCLES = 3000000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [8*LANES-1:0]   wr_data,
  input  logic                 prog_done,
  output logic                 wr_permit,
  output logic                 prot_mode,
  output logic [2:0]           seq_state
);
  localparam int CW = $clog2(LOCK_CYCLES + 2);
  localparam logic [ADDR_W-1:0] ADR_MAIN = ADDR_W'(17'h05555);
  localparam logic [ADDR_W-1:0] ADR_ALT0 = ADDR_W'(17'h02AAA);
  localparam logic [ADDR_W-1:0] ADR_ALT1 = ADDR_W'(17'h0AAAA);

  logic [LANES-1:0] lane_eq;
  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign lane_eq[g] = (wr_data[8*g +: 8] == wr_data[7:0]);
    end
  endgenerate

  wire       uniform = &lane_eq;
  wire [7:0] cbyte   = wr_data[7:0];
  wire       at_main = (wr_addr == ADR_MAIN);
  wire       at_alt  = (wr_addr == ADR_ALT0) || (wr_addr == ADR_ALT1);
  wire       hit_aa  = uniform && at_main && (cbyte == 8'hAA);
  wire       hit_55  = uniform && at_alt  && (cbyte == 8'h55);
  wire       hit_a0  = uniform && at_main && (cbyte == 8'hA0);
  wire       hit_80  = uniform && at_main && (cbyte == 8'h80);
  wire       hit_20  = uniform && at_main && (cbyte == 8'h20);

  logic [2:0]    step;
  logic          armed;
  logic          prot;
  logic [CW-1:0] lock_cnt;
  logic          advance;

  wire locked = (lock_cnt != '0);
  wire track  = wr_valid && !locked && !armed;

  always_comb begin
    case (step)
      3'd0:    advance = hit_aa;
      3'd1:    advance = hit_55;
      3'd2:    advance = hit_a0 || hit_80;
      3'd3:    advance = hit_aa;
      3'd4:    advance = hit_55;
      3'd5:    advance = hit_20;
      default: advance = 1'b0;
    endcase
  end

  wire consume = track && advance;

  assign wr_permit = wr_valid && !locked && (armed || (!consume && !prot));
  assign prot_mode = prot;
  assign seq_state = locked ? 3'd7 : (armed ? 3'd6 : step);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step     <= 3'd0;
      armed    <= 1'b0;
      prot     <= 1'b0;
      lock_cnt <= '0;
    end else begin
      if (locked) lock_cnt <= lock_cnt - 1'b1;
      if (prog_done) armed <= 1'b0;
      if (track) begin
        if (!advance) begin
          step <= 3'd0;
        end else begin
          case (step)
            3'd2: begin
              if (hit_a0) begin
                step <= 3'd0;
                if (prot) armed <= 1'b1;
                else begin
                  prot     <= 1'b1;
                  lock_cnt <= CW'(LOCK_CYCLES);
                end
              end else begin
                step <= 3'd3;
              end
            end
            3'd5: begin
              step     <= 3'd0;
              prot     <= 1'b0;
              lock_cnt <= CW'(LOCK_CYCLES);
            end
            default: step <= step + 3'd1;
          endcase
        end
      end
    end
  end

  assert_lock_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd7) |-> !wr_permit);

  assert_permit_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_permit |-> wr_valid);

  assert_mode_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_mode != $past(prot_mode)) |-> $past(wr_valid));

  assert_change_locks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_mode != $past(prot_mode)) |-> (LOCK_CYCLES == 0 || seq_state == 3'd7));

  assert_protected_refuses_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_mode && seq_state != 3'd6) |-> !wr_permit);
endmodule

// File: tb/wp_cmd_guard_bench.sv
module wp_cmd_guard_bench;
  localparam int AW = 17;
  localparam int LN = 5;
  localparam int LK = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [8*LN-1:0] wr_data = '0;
  logic prog_done = 1'b0;
  logic wr_permit, prot_mode;
  logic [2:0] seq_state;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  wp_cmd_guard #(.ADDR_W(AW), .LANES(LN), .LOCK_CYCLES(LK)) u_wp_cmd_guard (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .prog_done(prog_done), .wr_permit(wr_permit),
    .prot_mode(prot_mode), .seq_state(seq_state));

  function automatic logic [8*LN-1:0] rep(input logic [7:0] b);
    return {LN{b}};
  endfunction

  task automatic check(input int act, input int exp, input string tag);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic put(input logic [AW-1:0] a, input logic [8*LN-1:0] d,
                     input int exp_permit, input string tag);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    #1 check(int'(wr_permit), exp_permit, tag);
    @(posedge clk);
    #1 wr_valid = 1'b0;
  endtask

  task automatic wait_lock();
    repeat (LK + 2) @(posedge clk);
    #1 check(int'(seq_state), 0, "R4 lockout ended");
  endtask

  task automatic protect_seq(input string tag);
    put(17'h05555, rep(8'hAA), 0, tag);
    check(int'(seq_state), 1, "R12 step 1");
    put(17'h02AAA, rep(8'h55), 0, tag);
    check(int'(seq_state), 2, "R12 step 2");
    put(17'h05555, rep(8'hA0), 0, tag);
  endtask

  task automatic t_reset();
    check(int'(prot_mode), 0, "R1 mode");
    check(int'(seq_state), 0, "R1 state");
    check(int'(wr_permit), 0, "R1 permit");
  endtask

  task automatic t_plain_unprot();
    put(17'h00100, 40'h1234567890, 1, "R2 plain write");
    put(17'h05555, rep(8'h11), 1, "R2 other byte at cmd address");
  endtask

  task automatic t_enable();
    protect_seq("R3 cmd step not permitted");
    check(int'(prot_mode), 1, "R3 protected");
    check(int'(seq_state), 7, "R4 lockout entered");
    put(17'h00200, rep(8'h01), 0, "R4 write during lockout");
    check(int'(seq_state), 7, "R4 lockout state holds");
    check(int'(prot_mode), 1, "R4 mode unchanged in lockout");
    wait_lock();
  endtask

  task automatic t_protected_plain();
    put(17'h00300, rep(8'h77), 0, "R5 unsequenced write refused");
    check(int'(prot_mode), 1, "R5 mode kept");
  endtask

  task automatic t_window();
    protect_seq("R6 cmd step not permitted");
    check(int'(seq_state), 6, "R6 window open");
    check(int'(prot_mode), 1, "R6 mode kept");
    put(17'h00400, 40'hDEADBEEF01, 1, "R6 load 1");
    put(17'h00401, 40'h0102030405, 1, "R6 load 2");
    @(negedge clk); prog_done = 1'b1;
    @(posedge clk); #1 prog_done = 1'b0;
    check(int'(seq_state), 0, "R7 window closed");
    put(17'h00402, rep(8'h33), 0, "R7 refused after prog_done");
  endtask

  task automatic t_break_prot();
    put(17'h05555, rep(8'hAA), 0, "R9 first step");
    put(17'h00010, rep(8'h55), 0, "R9 breaking write refused");
    check(int'(seq_state), 0, "R9 back to idle");
    put(17'h05555, rep(8'hAA), 0, "R10 first step");
    put(17'h02AAA, 40'h5555555554, 0, "R10 mismatched lanes refused");
    check(int'(seq_state), 0, "R10 aborted");
  endtask

  task automatic t_disable();
    put(17'h05555, rep(8'hAA), 0, "R8 s1");
    put(17'h0AAAA, rep(8'h55), 0, "R11 alt address step");
    check(int'(seq_state), 2, "R11 alt address accepted");
    put(17'h05555, rep(8'h80), 0, "R8 s3");
    check(int'(seq_state), 3, "R12 step 3");
    put(17'h05555, rep(8'hAA), 0, "R8 s4");
    put(17'h02AAA, rep(8'h55), 0, "R8 s5");
    check(int'(seq_state), 5, "R12 step 5");
    put(17'h05555, rep(8'h20), 0, "R8 s6");
    check(int'(prot_mode), 0, "R8 unprotected");
    check(int'(seq_state), 7, "R8 lockout");
    wait_lock();
    put(17'h00500, rep(8'h42), 1, "R8 write passes after unlock");
  endtask

  task automatic t_break_unprot();
    put(17'h05555, rep(8'hAA), 0, "R9 first step unprotected");
    put(17'h00600, rep(8'h99), 1, "R9 breaking write passes");
    check(int'(seq_state), 0, "R9 idle after break");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_plain_unprot();
    t_enable();
    t_protected_plain();
    t_window();
    t_break_prot();
    t_disable();
    t_break_unprot();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule